// File: doc/BRIEF.md
# Dual-Policy Issue Queue

This block is the holding queue that sits between an in-order allocate/rename stage and one execution unit in an out-of-order core. Up to two micro-ops arrive per cycle, each carrying two source operands described by a physical tag and a ready bit. The queue watches a result-tag broadcast bus and marks operands ready as their producers finish. Each cycle it hands at most one op with both operands ready to its execution unit.

A parameter chooses the issue policy when the block is built. With any-slot issue, which fits an integer ALU, the oldest op that is ready is picked, wherever it sits in the queue. With head-only issue, which fits address generation or floating point, only the oldest op may leave. A head that is not ready holds back every younger op, including younger ops that are ready. The queue never waits for an issued op to complete, so ops that issue in order may still finish out of order further down the pipe.

Entries are kept compacted in allocation order, so entry 0 is always the oldest. The queue reports how many slots are free and takes only as many incoming ops as fit. The upstream stage keeps whatever was not taken. A flush empties the queue in one cycle.

Top module: `rs_station`

## Requirements
- R1: Up to two ops are accepted per cycle. `alloc_take[0]` marks lane 0 as taken and `alloc_take[1]` marks lane 1 as taken. A lone valid lane 1 is taken when at least one slot is free.
- R2: At most one op is dispatched per cycle, and only when both of its source ready bits are set. Each accepted op is dispatched exactly once.
- R3: With any-slot policy, the oldest ready entry is dispatched, even when older entries that are not ready sit ahead of it.
- R4: With head-only policy, only the oldest entry may dispatch. While that entry is not ready, nothing dispatches, even if younger entries are ready.
- R5: A broadcast with `wb_valid` high sets the ready bit of every stored source whose tag equals `wb_tag`, in all entries at once. The woken op can dispatch in the following cycle.
- R6: An op allocated in the same cycle as a broadcast of one of its source tags captures that wakeup. It can dispatch in the next cycle.
- R7: `free_slots` equals DEPTH minus the current occupancy, and the number of ops taken never exceeds it. With one slot free and both lanes valid, only lane 0 is taken, and a full queue takes nothing.
- R8: While `flush` is high, nothing dispatches and nothing is taken. In the next cycle the queue is empty.
- R9: The queue never waits for completion. In head-only mode, consecutive ready ops dispatch on back-to-back cycles.
- R10: After reset the queue is empty, `free_slots` equals DEPTH, and `disp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties the queue and blocks dispatch and allocation this cycle |
| a0_valid | input | 1 | Lane 0 offers an op |
| a0_tag1 | input | TAG_W | Lane 0 first source tag |
| a0_rdy1 | input | 1 | Lane 0 first source already ready |
| a0_tag2 | input | TAG_W | Lane 0 second source tag |
| a0_rdy2 | input | 1 | Lane 0 second source already ready |
| a0_pay | input | PAY_W | Lane 0 op payload |
| a1_valid | input | 1 | Lane 1 offers an op (younger than lane 0) |
| a1_tag1 | input | TAG_W | Lane 1 first source tag |
| a1_rdy1 | input | 1 | Lane 1 first source already ready |
| a1_tag2 | input | TAG_W | Lane 1 second source tag |
| a1_rdy2 | input | 1 | Lane 1 second source already ready |
| a1_pay | input | PAY_W | Lane 1 op payload |
| wb_valid | input | 1 | Result broadcast valid |
| wb_tag | input | TAG_W | Result broadcast tag |
| alloc_take | output | 2 | Per-lane accept flags for this cycle |
| free_slots | output | $clog2(DEPTH+1) | Number of empty entries |
| disp_valid | output | 1 | An op is dispatched this cycle |
| disp_pay | output | PAY_W | Payload of the dispatched op |

## Verification
The hardest case to reach is a younger ready op stuck behind a head that is not ready, at the same moment an any-slot queue would let it pass. The bench drives one stimulus stream into two instances, one built with each policy. The same allocations and broadcasts therefore yield opposite dispatch orders, and a scoreboard checks each order. Filling the queue to exactly one free slot, and flushing while a ready head is waiting, are reached by directed sequences of broadcasts that are held back.

// File: rtl/rs_pkg.sv
package rs_pkg;

  typedef enum logic {
    POL_ANY_SLOT    = 1'b0,
    POL_OLDEST_ONLY = 1'b1
  } policy_e;

  // Lane grant: lane 0 is older and wins a single free slot.
  function automatic logic [1:0] grant_lanes(input logic v0, input logic v1,
                                             input int unsigned room);
    logic [1:0] g;
    g = 2'b00;
    if (room >= 2) begin
      g = {v1, v0};
    end else if (room == 1) begin
      if (v0)      g = 2'b01;
      else if (v1) g = 2'b10;
    end
    return g;
  endfunction

endpackage

// File: rtl/rs_wake.sv
module rs_wake #(
  parameter int TAG_W = 6
) (
  input  logic [TAG_W-1:0] src_tag,
  input  logic             src_rdy,
  input  logic             wb_valid,
  input  logic [TAG_W-1:0] wb_tag,
  output logic             rdy_o
);
  function automatic logic hit(input logic v, input logic [TAG_W-1:0] a,
                               input logic [TAG_W-1:0] b);
    return v && (a == b);
  endfunction

  assign rdy_o = src_rdy | hit(wb_valid, src_tag, wb_tag);
endmodule

// File: rtl/rs_alloc.sv
module rs_alloc #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] count,
  input  logic             flush,
  input  logic             v0,
  input  logic             v1,
  output logic [1:0]       take,
  output logic [1:0]       n_take,
  output logic [CNT_W-1:0] free
);
  assign free   = CNT_W'(DEPTH) - count;
  assign take   = flush ? 2'b00 : rs_pkg::grant_lanes(v0, v1, 32'(free));
  assign n_take = {1'b0, take[0]} + {1'b0, take[1]};
endmodule

// File: rtl/rs_select.sv
module rs_select #(
  parameter int              DEPTH  = 8,
  parameter rs_pkg::policy_e POLICY = rs_pkg::POL_ANY_SLOT,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] occ,
  input  logic [DEPTH-1:0] rdy,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  logic [DEPTH-1:0] cand;
  assign cand = occ & rdy;

  generate
    if (POLICY == rs_pkg::POL_ANY_SLOT) begin : g_any
      // Lowest index is oldest: scan from the top so the lowest wins.
      always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
          if (cand[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
          end
        end
      end
    end else begin : g_head
      assign found = cand[0];
      assign idx   = '0;
    end
  endgenerate
endmodule

// File: rtl/rs_station.sv
module rs_station #(
  parameter int              DEPTH  = 8,
  parameter int              TAG_W  = 6,
  parameter int              PAY_W  = 8,
  parameter rs_pkg::policy_e POLICY = rs_pkg::POL_ANY_SLOT,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             a0_valid,
  input  logic [TAG_W-1:0] a0_tag1,
  input  logic             a0_rdy1,
  input  logic [TAG_W-1:0] a0_tag2,
  input  logic             a0_rdy2,
  input  logic [PAY_W-1:0] a0_pay,
  input  logic             a1_valid,
  input  logic [TAG_W-1:0] a1_tag1,
  input  logic             a1_rdy1,
  input  logic [TAG_W-1:0] a1_tag2,
  input  logic             a1_rdy2,
  input  logic [PAY_W-1:0] a1_pay,
  input  logic             wb_valid,
  input  logic [TAG_W-1:0] wb_tag,
  output logic [1:0]       alloc_take,
  output logic [CNT_W-1:0] free_slots,
  output logic             disp_valid,
  output logic [PAY_W-1:0] disp_pay
);
  // Storage, compacted: entry 0 is the oldest.
  logic [TAG_W-1:0] t1_q [DEPTH];
  logic [TAG_W-1:0] t2_q [DEPTH];
  logic             r1_q [DEPTH];
  logic             r2_q [DEPTH];
  logic [PAY_W-1:0] pay_q [DEPTH];
  logic [CNT_W-1:0] count_q;

  logic [TAG_W-1:0] t1_d [DEPTH];
  logic [TAG_W-1:0] t2_d [DEPTH];
  logic             r1_d [DEPTH];
  logic             r2_d [DEPTH];
  logic [PAY_W-1:0] pay_d [DEPTH];
  logic [CNT_W-1:0] count_d;

  // Named internal events for assertions.
  logic             r1_w [DEPTH];
  logic             r2_w [DEPTH];
  logic [DEPTH-1:0] occ;
  logic [DEPTH-1:0] rdy_vec;
  logic             sel_found;
  logic [IDX_W-1:0] sel_idx;
  logic             disp_fire;
  logic [1:0]       n_take;
  logic             in0_r1, in0_r2, in1_r1, in1_r2;

  // Wakeup of stored sources.
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    rs_wake #(.TAG_W(TAG_W)) u_w1 (
      .src_tag(t1_q[g]), .src_rdy(r1_q[g]),
      .wb_valid(wb_valid), .wb_tag(wb_tag), .rdy_o(r1_w[g]));
    rs_wake #(.TAG_W(TAG_W)) u_w2 (
      .src_tag(t2_q[g]), .src_rdy(r2_q[g]),
      .wb_valid(wb_valid), .wb_tag(wb_tag), .rdy_o(r2_w[g]));
    assign occ[g]     = CNT_W'(g) < count_q;
    assign rdy_vec[g] = r1_q[g] & r2_q[g];
  end

  // Wakeup of incoming sources (same-cycle capture).
  rs_wake #(.TAG_W(TAG_W)) u_i01 (.src_tag(a0_tag1), .src_rdy(a0_rdy1),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .rdy_o(in0_r1));
  rs_wake #(.TAG_W(TAG_W)) u_i02 (.src_tag(a0_tag2), .src_rdy(a0_rdy2),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .rdy_o(in0_r2));
  rs_wake #(.TAG_W(TAG_W)) u_i11 (.src_tag(a1_tag1), .src_rdy(a1_rdy1),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .rdy_o(in1_r1));
  rs_wake #(.TAG_W(TAG_W)) u_i12 (.src_tag(a1_tag2), .src_rdy(a1_rdy2),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .rdy_o(in1_r2));

  rs_alloc #(.DEPTH(DEPTH)) u_alloc (
    .count(count_q), .flush(flush), .v0(a0_valid), .v1(a1_valid),
    .take(alloc_take), .n_take(n_take), .free(free_slots));

  rs_select #(.DEPTH(DEPTH), .POLICY(POLICY)) u_sel (
    .occ(occ), .rdy(rdy_vec), .found(sel_found), .idx(sel_idx));

  assign disp_fire  = sel_found & ~flush;
  assign disp_valid = disp_fire;
  assign disp_pay   = pay_q[sel_idx];

  // Next state: remove the dispatched entry, shift younger ones down,
  // then append the accepted ops behind the survivors.
  always_comb begin
    logic [CNT_W-1:0] kept;
    logic [CNT_W-1:0] slot1;
    logic [IDX_W-1:0] src;
    kept  = count_q - CNT_W'(disp_fire);
    slot1 = kept + CNT_W'(alloc_take[0]);
    for (int i = 0; i < DEPTH; i++) begin
      if (disp_fire && IDX_W'(i) >= sel_idx) src = IDX_W'(i + 1);
      else                                   src = IDX_W'(i);
      t1_d[i]  = t1_q[src];
      t2_d[i]  = t2_q[src];
      r1_d[i]  = r1_w[src];
      r2_d[i]  = r2_w[src];
      pay_d[i] = pay_q[src];
      if (alloc_take[0] && CNT_W'(i) == kept) begin
        t1_d[i] = a0_tag1; t2_d[i] = a0_tag2;
        r1_d[i] = in0_r1;  r2_d[i] = in0_r2;
        pay_d[i] = a0_pay;
      end
      if (alloc_take[1] && CNT_W'(i) == slot1) begin
        t1_d[i] = a1_tag1; t2_d[i] = a1_tag2;
        r1_d[i] = in1_r1;  r2_d[i] = in1_r2;
        pay_d[i] = a1_pay;
      end
    end
    count_d = flush ? '0 : kept + CNT_W'(n_take);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      t1_q[i]  <= t1_d[i];
      t2_q[i]  <= t2_d[i];
      r1_q[i]  <= r1_d[i];
      r2_q[i]  <= r2_d[i];
      pay_q[i] <= pay_d[i];
    end
  end

  // R2: a dispatched entry has both stored sources ready
  a_r2_ready_only: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (occ[sel_idx] && r1_q[sel_idx] && r2_q[sel_idx]));

  // R4: head-only policy issues from entry 0 and nowhere else
  a_r4_head_only: assert property (@(posedge clk) disable iff (!rst_n)
    (POLICY == rs_pkg::POL_OLDEST_ONLY && disp_valid) |-> sel_idx == '0);

  // R4: a head that is not ready blocks every younger entry
  a_r4_head_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (POLICY == rs_pkg::POL_OLDEST_ONLY && count_q != '0 && !(r1_q[0] && r2_q[0]))
      |-> !disp_valid);

  // R7: never take more ops than free slots
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(alloc_take) <= 32'(free_slots));

  // R7: occupancy follows allocations and dispatches
  a_r7_count_track: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(flush) |-> free_slots ==
      $past(free_slots) + CNT_W'($past(disp_valid)) - CNT_W'($past(n_take)));

  // R8: flush blocks dispatch and allocation, then leaves the queue empty
  a_r8_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!disp_valid && alloc_take == 2'b00));
  a_r8_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> free_slots == CNT_W'(DEPTH));
endmodule

// File: tb/rs_station_tb.sv
module rs_station_tb;
  localparam int DEPTH = 8;
  localparam int TAG_W = 6;
  localparam int PAY_W = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, flush, a0_valid, a0_rdy1, a0_rdy2, a1_valid, a1_rdy1, a1_rdy2, wb_valid;
  logic [TAG_W-1:0] a0_tag1, a0_tag2, a1_tag1, a1_tag2, wb_tag;
  logic [PAY_W-1:0] a0_pay, a1_pay;

  logic [1:0]       take_a, take_h;
  logic [CNT_W-1:0] free_a, free_h;
  logic             dv_a, dv_h;
  logic [PAY_W-1:0] dp_a, dp_h;

  rs_station #(.DEPTH(DEPTH), .TAG_W(TAG_W), .PAY_W(PAY_W),
               .POLICY(rs_pkg::POL_ANY_SLOT)) u_dut (
    .clk, .rst_n, .flush,
    .a0_valid, .a0_tag1, .a0_rdy1, .a0_tag2, .a0_rdy2, .a0_pay,
    .a1_valid, .a1_tag1, .a1_rdy1, .a1_tag2, .a1_rdy2, .a1_pay,
    .wb_valid, .wb_tag,
    .alloc_take(take_a), .free_slots(free_a), .disp_valid(dv_a), .disp_pay(dp_a));

  rs_station #(.DEPTH(DEPTH), .TAG_W(TAG_W), .PAY_W(PAY_W),
               .POLICY(rs_pkg::POL_OLDEST_ONLY)) u_dut_head (
    .clk, .rst_n, .flush,
    .a0_valid, .a0_tag1, .a0_rdy1, .a0_tag2, .a0_rdy2, .a0_pay,
    .a1_valid, .a1_tag1, .a1_rdy1, .a1_tag2, .a1_rdy2, .a1_pay,
    .wb_valid, .wb_tag,
    .alloc_take(take_h), .free_slots(free_h), .disp_valid(dv_h), .disp_pay(dp_h));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [PAY_W-1:0] exp_a[$];
  logic [PAY_W-1:0] exp_h[$];

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor: every dispatch must match the next expected payload.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (dv_a) begin
        if (exp_a.size() == 0) chk("R2", "any-slot unexpected dispatch", 32'(dp_a), 32'hFFFF);
        else chk("R2", "any-slot dispatch order", 32'(dp_a), 32'(exp_a.pop_front()));
      end
      if (dv_h) begin
        if (exp_h.size() == 0) chk("R2", "head-only unexpected dispatch", 32'(dp_h), 32'hFFFF);
        else chk("R2", "head-only dispatch order", 32'(dp_h), 32'(exp_h.pop_front()));
      end
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic idle();
    flush = 0; a0_valid = 0; a1_valid = 0; wb_valid = 0;
  endtask

  task automatic lane0(input logic [7:0] id, input logic [5:0] t1, input logic r1,
                       input logic [5:0] t2, input logic r2);
    a0_valid = 1; a0_pay = id; a0_tag1 = t1; a0_rdy1 = r1; a0_tag2 = t2; a0_rdy2 = r2;
  endtask

  task automatic lane1(input logic [7:0] id, input logic [5:0] t1, input logic r1,
                       input logic [5:0] t2, input logic r2);
    a1_valid = 1; a1_pay = id; a1_tag1 = t1; a1_rdy1 = r1; a1_tag2 = t2; a1_rdy2 = r2;
  endtask

  task automatic bcast(input logic [5:0] t);
    wb_valid = 1; wb_tag = t;
  endtask

  task automatic push_both(input logic [7:0] id);
    exp_a.push_back(id); exp_h.push_back(id);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle();
    a0_pay = 0; a1_pay = 0; a0_tag1 = 0; a0_tag2 = 0; a1_tag1 = 0; a1_tag2 = 0;
    a0_rdy1 = 0; a0_rdy2 = 0; a1_rdy1 = 0; a1_rdy2 = 0; wb_tag = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "free any", 32'(free_a), DEPTH);
    chk("R10", "free head", 32'(free_h), DEPTH);
    chk("R10", "disp any", 32'(dv_a), 0);
    chk("R10", "disp head", 32'(dv_h), 0);

    // R3/R4: older op waits on tag 5, younger op ready
    tick(); lane0(8'd1, 6'd5, 0, 6'd1, 1); lane1(8'd2, 6'd2, 1, 6'd3, 1);
    exp_a.push_back(8'd2); exp_a.push_back(8'd1);
    exp_h.push_back(8'd1); exp_h.push_back(8'd2);
    @(negedge clk);
    chk("R1", "two-lane take any", 32'(take_a), 2'b11);
    chk("R1", "two-lane take head", 32'(take_h), 2'b11);
    tick(); idle(); @(negedge clk);
    chk("R3", "younger ready op issues past older", 32'(dv_a), 1);
    chk("R4", "head not ready blocks", 32'(dv_h), 0);
    tick(); bcast(6'd5); @(negedge clk);
    chk("R4", "still blocked during broadcast", 32'(dv_h), 0);
    chk("R5", "no issue before wakeup lands", 32'(dv_a), 0);
    tick(); idle(); @(negedge clk);
    chk("R5", "woken op issues any", 32'(dv_a), 1);
    chk("R5", "woken head issues", 32'(dv_h), 1);
    tick(); @(negedge clk);
    chk("R9", "back-to-back head issue", 32'(dv_h), 1);
    tick(); @(negedge clk);
    chk("R7", "free after drain any", 32'(free_a), DEPTH);
    chk("R7", "free after drain head", 32'(free_h), DEPTH);

    // R6: allocation in the same cycle as its broadcast
    tick(); lane0(8'd3, 6'd9, 0, 6'd9, 0); bcast(6'd9); push_both(8'd3);
    @(negedge clk);
    chk("R1", "single lane0 take", 32'(take_a), 2'b01);
    tick(); idle(); @(negedge clk);
    chk("R6", "same-cycle capture any", 32'(dv_a), 1);
    chk("R6", "same-cycle capture head", 32'(dv_h), 1);

    // R5: one broadcast wakes several sources in several entries
    tick(); idle(); lane0(8'd4, 6'd12, 0, 6'd12, 0); lane1(8'd5, 6'd7, 1, 6'd12, 0);
    push_both(8'd4); push_both(8'd5);
    tick(); idle(); bcast(6'd12); @(negedge clk);
    chk("R5", "nothing ready before broadcast", 32'(dv_a), 0);
    tick(); idle(); @(negedge clk);
    chk("R5", "multi-match wake any", 32'(dv_a), 1);
    tick(); @(negedge clk);
    chk("R5", "second woken entry head", 32'(dv_h), 1);

    // R3: oldest ready wins among several ready entries
    tick(); idle(); lane0(8'd6, 6'd20, 0, 6'd1, 1); lane1(8'd7, 6'd1, 1, 6'd1, 1);
    exp_a.push_back(8'd7); exp_a.push_back(8'd8); exp_a.push_back(8'd6);
    exp_h.push_back(8'd6); exp_h.push_back(8'd7); exp_h.push_back(8'd8);
    tick(); idle(); lane0(8'd8, 6'd1, 1, 6'd1, 1); @(negedge clk);
    chk("R3", "oldest ready chosen any", 32'(dp_a), 7);
    tick(); idle(); @(negedge clk);
    chk("R3", "next ready chosen any", 32'(dp_a), 8);
    chk("R4", "head blocked on tag 20", 32'(dv_h), 0);
    tick(); bcast(6'd20);
    tick(); idle();
    repeat (4) tick();

    // R7: fill to the limit
    for (int k = 0; k < 3; k++) begin
      tick(); idle();
      lane0(8'(10 + 2 * k), 6'd30, 0, 6'd1, 1);
      lane1(8'(11 + 2 * k), 6'd30, 0, 6'd1, 1);
      push_both(8'(10 + 2 * k)); push_both(8'(11 + 2 * k));
    end
    tick(); idle(); lane0(8'd16, 6'd30, 0, 6'd1, 1); push_both(8'd16);
    tick(); idle(); @(negedge clk);
    chk("R7", "one slot free", 32'(free_a), 1);
    tick(); lane0(8'd17, 6'd30, 0, 6'd1, 1); lane1(8'd18, 6'd30, 0, 6'd1, 1);
    push_both(8'd17); @(negedge clk);
    chk("R7", "one slot: lane0 only any", 32'(take_a), 2'b01);
    chk("R7", "one slot: lane0 only head", 32'(take_h), 2'b01);
    tick(); lane0(8'd19, 6'd30, 0, 6'd1, 1); lane1(8'd20, 6'd30, 0, 6'd1, 1);
    @(negedge clk);
    chk("R7", "full takes nothing", 32'(take_a), 0);
    chk("R7", "full free count", 32'(free_h), 0);
    tick(); idle(); bcast(6'd30);
    tick(); idle();
    repeat (10) tick();
    @(negedge clk);
    chk("R7", "drained after fill", 32'(free_a), DEPTH);

    // R8: flush with a ready head pending
    tick(); lane0(8'd21, 6'd1, 1, 6'd1, 1); lane1(8'd22, 6'd40, 0, 6'd1, 1);
    tick(); idle(); flush = 1; lane0(8'd23, 6'd1, 1, 6'd1, 1); @(negedge clk);
    chk("R8", "flush blocks dispatch any", 32'(dv_a), 0);
    chk("R8", "flush blocks dispatch head", 32'(dv_h), 0);
    chk("R8", "flush blocks allocation", 32'(take_a), 0);
    tick(); idle(); @(negedge clk);
    chk("R8", "empty after flush", 32'(free_h), DEPTH);
    tick(); bcast(6'd40);
    tick(); idle(); @(negedge clk);
    chk("R8", "flushed op stays gone", 32'(dv_a), 0);

    // R1: lone lane 1
    tick(); lane1(8'd25, 6'd1, 1, 6'd1, 1); push_both(8'd25); @(negedge clk);
    chk("R1", "lone lane1 taken", 32'(take_a), 2'b10);
    tick(); idle(); @(negedge clk);
    chk("R1", "lone lane1 dispatched", 32'(dv_h), 1);

    repeat (3) tick();
    @(negedge clk);
    chk("R2", "every op issued once any", 32'(exp_a.size()), 0);
    chk("R2", "every op issued once head", 32'(exp_h.size()), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule